// File: doc/BRIEF.md
# Isochronous Transaction Slot Engine

This block handles a single isochronous transaction slot for a host controller. A scheduler offers it a 32-bit slot control word and the transfer direction. It also supplies a bank of seven buffer page pointers, each aligned to 4 KB. If the slot is armed, the engine builds the starting buffer address and the byte count. It passes them to a transfer engine through a valid/ready request channel and then waits for that engine's result. The result is a byte count plus three flags: overrun/underrun, babble and no-response.

From that result the engine produces an updated slot word and emits it on a one-cycle write-back strobe. In the updated word the arm bit is cleared and the error bits are OR-ed into any bits already present. A slot whose page select or length is outside the legal range is never sent to the transfer engine. Instead it is disarmed at once, and a programming-error pulse is raised alongside its write-back.

When a written-back word has its interrupt-on-complete bit set, a completion interrupt is queued. The interrupt output is only raised on the next threshold tick. It then stays high until software acknowledges it.

Top module: `iso_slot_engine`

## Requirements
- R1: A slot offered while its arm bit (bit 31) is 0 is ignored. No request, no write-back and no error pulse follow, and the engine stays ready.
- R2: The request address is bits 31:12 of the page pointer selected by bits 14:12 of the word, with the 12-bit offset (bits 11:0) as its low bits. The request length is bits 27:16 and the request direction is the offered direction (1 = IN).
- R3: A slot with page select 7 or length above 3072 is never requested. One cycle after acceptance, the engine emits the offered word with bit 31 cleared on a write-back strobe, together with a one-cycle error pulse.
- R4: While a request is not yet accepted, the request valid stays high and the address, length and direction stay unchanged.
- R5: Each accepted armed slot produces exactly one single-cycle write-back, and the written word always has bit 31 cleared. For a legal slot this write-back comes in the cycle after the result is accepted.
- R6: For an IN slot the written length field (27:16) is the reported byte count, where 0 means a zero-length packet. For an OUT slot the length field is left unchanged.
- R7: Bit 30 is set when the result reports overrun/underrun, and bit 29 is set when it reports babble. Both bits are kept if they were already set.
- R8: Bit 28 is set by a no-response result only for IN slots. An OUT slot leaves it as it was.
- R9: A write-back whose bit 15 is set queues an interrupt. The interrupt output rises on the first threshold tick after the write-back cycle, and several queued completions produce a single interrupt. It stays high until acknowledged. If a tick and an acknowledge arrive in the same cycle, the set takes priority.
- R10: The engine is ready for a new slot only when idle. A slot offered while it is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sched_valid | input | 1 | A slot is offered |
| sched_ready | output | 1 | Engine idle and able to take a slot |
| sched_word | input | 32 | Slot control word |
| sched_is_in | input | 1 | Direction of the offered slot, 1 = IN |
| page_list | input | 224 | Seven page pointers, pointer i at bits 32i+31:32i |
| req_valid | output | 1 | Transfer request valid |
| req_ready | input | 1 | Transfer engine takes the request |
| req_addr | output | 32 | Starting buffer address |
| req_len | output | 12 | Byte count to transfer |
| req_is_in | output | 1 | Request direction, 1 = IN |
| rsp_valid | input | 1 | Transfer result valid |
| rsp_ready | output | 1 | Engine waits for a result |
| rsp_bytes | input | 12 | Bytes actually moved |
| rsp_buf_err | input | 1 | Overrun or underrun |
| rsp_babble | input | 1 | Babble seen |
| rsp_noresp | input | 1 | No valid device response |
| wb_valid | output | 1 | Write-back strobe |
| wb_word | output | 32 | Updated slot word |
| prog_err | output | 1 | Illegal slot rejected |
| thresh_tick | input | 1 | Interrupt threshold point |
| irq_ack | input | 1 | Software acknowledge |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions assume that the transfer engine follows the handshake. It must not offer a result unless the engine shows result-ready, and the engine's request is taken only through req_ready. The stimulus keeps to this: results are driven only in the waiting phase, and only for one cycle after rsp_ready is observed. The assertions also assume the page list stays constant for the whole life of a slot, so the stimulus fixes it before reset and never changes it. Intruding slot offers, ticks and acknowledges may arrive in any cycle, because the design is required to absorb them.

// File: rtl/iso_slot_pkg.sv
package iso_slot_pkg;

    localparam int ADDR_W     = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int PFN_W      = ADDR_W - PAGE_SHIFT;
    localparam int LEN_W      = 12;
    localparam int SEL_W      = 3;
    localparam int PAGE_COUNT = 7;
    localparam int MAX_LEN    = 3072;

    typedef struct packed {
        logic               active;
        logic               buf_err;
        logic               babble;
        logic               xact_err;
        logic [LEN_W-1:0]   len;
        logic               ioc;
        logic [SEL_W-1:0]   pg;
        logic [PAGE_SHIFT-1:0] off;
    } slot_word_t;

    typedef struct packed {
        logic [LEN_W-1:0] bytes;
        logic             buf_err;
        logic             babble;
        logic             noresp;
    } xfer_result_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_WB
    } eng_state_t;

    function automatic logic slot_legal(slot_word_t w, int pages);
        return (int'(w.pg) < pages) && (int'(w.len) <= MAX_LEN);
    endfunction

endpackage

// File: rtl/iso_addr_gen.sv
module iso_addr_gen
    import iso_slot_pkg::*;
#(
    parameter int NUM_PAGES = PAGE_COUNT
) (
    input  logic [NUM_PAGES*ADDR_W-1:0] page_list,
    input  slot_word_t                  slot,
    output logic [ADDR_W-1:0]           addr
);

    logic [PFN_W-1:0] pfn [NUM_PAGES];
    logic [PFN_W-1:0] sel_pfn;

    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_pfn
        assign pfn[g] = page_list[g*ADDR_W+PAGE_SHIFT +: PFN_W];
    end

    always_comb begin
        sel_pfn = '0;
        for (int i = 0; i < NUM_PAGES; i++) begin
            if (slot.pg == SEL_W'(i)) sel_pfn = pfn[i];
        end
        addr = {sel_pfn, slot.off};
    end

endmodule

// File: rtl/iso_status_merge.sv
module iso_status_merge
    import iso_slot_pkg::*;
(
    input  slot_word_t   orig,
    input  logic         is_in,
    input  xfer_result_t res,
    output slot_word_t   upd
);

    always_comb begin
        upd          = orig;
        upd.active   = 1'b0;
        upd.buf_err  = orig.buf_err | res.buf_err;
        upd.babble   = orig.babble  | res.babble;
        upd.xact_err = orig.xact_err | (res.noresp & is_in);
        if (is_in) upd.len = res.bytes;
    end

endmodule

// File: rtl/iso_irq_hold.sv
module iso_irq_hold (
    input  logic clk,
    input  logic rst,
    input  logic cmp_evt,
    input  logic tick,
    input  logic ack,
    output logic irq
);

    logic pend_q;
    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            pend_q <= cmp_evt | (pend_q & ~tick);
            if (tick && pend_q)
                irq_q <= 1'b1;
            else if (ack)
                irq_q <= 1'b0;
        end
    end

    assign irq = irq_q;

    AST_IRQ_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(tick)) else $error("irq rose without tick"); // R9
    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
        irq && !ack |=> irq) else $error("irq dropped without ack"); // R9

endmodule

// File: rtl/iso_slot_engine.sv
module iso_slot_engine
    import iso_slot_pkg::*;
#(
    parameter int NUM_PAGES = PAGE_COUNT
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        sched_valid,
    output logic                        sched_ready,
    input  logic [31:0]                 sched_word,
    input  logic                        sched_is_in,
    input  logic [NUM_PAGES*ADDR_W-1:0] page_list,
    output logic                        req_valid,
    input  logic                        req_ready,
    output logic [ADDR_W-1:0]           req_addr,
    output logic [LEN_W-1:0]            req_len,
    output logic                        req_is_in,
    input  logic                        rsp_valid,
    output logic                        rsp_ready,
    input  logic [LEN_W-1:0]            rsp_bytes,
    input  logic                        rsp_buf_err,
    input  logic                        rsp_babble,
    input  logic                        rsp_noresp,
    output logic                        wb_valid,
    output logic [31:0]                 wb_word,
    output logic                        prog_err,
    input  logic                        thresh_tick,
    input  logic                        irq_ack,
    output logic                        irq
);

    eng_state_t   state_q;
    slot_word_t   cur_q;
    logic         cur_in_q;
    slot_word_t   wb_q;
    logic         perr_q;
    slot_word_t   offered;
    slot_word_t   rejected;
    slot_word_t   merged;
    xfer_result_t res;

    assign offered = slot_word_t'(sched_word);
    assign res     = '{bytes: rsp_bytes, buf_err: rsp_buf_err,
                       babble: rsp_babble, noresp: rsp_noresp};

    always_comb begin
        rejected        = offered;
        rejected.active = 1'b0;
    end

    iso_addr_gen #(.NUM_PAGES(NUM_PAGES)) u_addr (
        .page_list (page_list),
        .slot      (cur_q),
        .addr      (req_addr)
    );

    iso_status_merge u_merge (
        .orig  (cur_q),
        .is_in (cur_in_q),
        .res   (res),
        .upd   (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cur_q    <= '0;
            cur_in_q <= 1'b0;
            wb_q     <= '0;
            perr_q   <= 1'b0;
        end else begin
            perr_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (sched_valid && offered.active) begin
                        cur_q    <= offered;
                        cur_in_q <= sched_is_in;
                        if (slot_legal(offered, NUM_PAGES)) begin
                            state_q <= ST_REQ;
                        end else begin
                            wb_q    <= rejected;
                            perr_q  <= 1'b1;
                            state_q <= ST_WB;
                        end
                    end
                end
                ST_REQ:  if (req_ready) state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (rsp_valid) begin
                        wb_q    <= merged;
                        state_q <= ST_WB;
                    end
                end
                ST_WB:   state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign sched_ready = (state_q == ST_IDLE);
    assign req_valid   = (state_q == ST_REQ);
    assign rsp_ready   = (state_q == ST_WAIT);
    assign req_len     = cur_q.len;
    assign req_is_in   = cur_in_q;
    assign wb_valid    = (state_q == ST_WB);
    assign wb_word     = wb_q;
    assign prog_err    = perr_q;

    iso_irq_hold u_irq (
        .clk     (clk),
        .rst     (rst),
        .cmp_evt (wb_valid & wb_q.ioc),
        .tick    (thresh_tick),
        .ack     (irq_ack),
        .irq     (irq)
    );

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len) && $stable(req_is_in))
        else $error("request changed before acceptance"); // R4
    AST_REQ_LEGAL: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (int'(req_len) <= MAX_LEN)) else $error("illegal length requested"); // R3
    AST_ERR_WITH_WB: assert property (@(posedge clk) disable iff (rst)
        prog_err |-> wb_valid && !req_valid) else $error("error pulse without write-back"); // R3
    AST_WB_DISARMED: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> !wb_word[31]) else $error("write-back left slot armed"); // R5
    AST_WB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wb_valid |=> !wb_valid) else $error("write-back longer than one cycle"); // R5
    AST_XERR_IN_ONLY: assert property (@(posedge clk) disable iff (rst)
        wb_valid && wb_word[28] && !cur_q.xact_err |-> cur_in_q)
        else $error("transaction error on OUT slot"); // R8
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        req_valid || rsp_ready || wb_valid |-> !sched_ready) else $error("ready while busy"); // R10

endmodule

// File: tb/iso_slot_engine_bench.sv
`timescale 1ns/1ps
module iso_slot_engine_bench;

    localparam int NP = 7;

    logic        clk = 1'b0;
    logic        rst;
    logic        sched_valid = 0, sched_is_in = 0;
    logic [31:0] sched_word = '0;
    logic [NP*32-1:0] page_list;
    logic        req_ready = 0, rsp_valid = 0;
    logic [11:0] rsp_bytes = '0;
    logic        rsp_buf_err = 0, rsp_babble = 0, rsp_noresp = 0;
    logic        thresh_tick = 0, irq_ack = 0;
    logic        sched_ready, req_valid, req_is_in, rsp_ready, wb_valid, prog_err, irq;
    logic [31:0] req_addr, wb_word;
    logic [11:0] req_len;

    int total = 0;
    int bad = 0;
    int wb_seen = 0;
    int wb_exp = 0;
    bit done = 0;
    bit m_irq = 0, m_pend = 0;

    always #2 clk = ~clk;

    iso_slot_engine u_iso_slot_engine (
        .clk(clk), .rst(rst), .sched_valid(sched_valid), .sched_ready(sched_ready),
        .sched_word(sched_word), .sched_is_in(sched_is_in), .page_list(page_list),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_is_in(req_is_in), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_bytes(rsp_bytes), .rsp_buf_err(rsp_buf_err),
        .rsp_babble(rsp_babble), .rsp_noresp(rsp_noresp), .wb_valid(wb_valid),
        .wb_word(wb_word), .prog_err(prog_err), .thresh_tick(thresh_tick),
        .irq_ack(irq_ack), .irq(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(bit act, bit be, bit bb, bit xe, int len,
                                       bit ioc, int pg, int off);
        return {act, be, bb, xe, 12'(len), ioc, 3'(pg), 12'(off)};
    endfunction

    // behavioural interrupt model, updated from port activity each edge
    always @(posedge clk) begin
        bit n_irq, n_pend;
        if (rst) begin
            m_irq <= 0; m_pend <= 0;
        end else begin
            n_irq = m_irq;
            if (irq_ack) n_irq = 0;
            if (thresh_tick && m_pend) n_irq = 1;
            n_pend = (wb_valid && wb_word[15]) || (m_pend && !thresh_tick);
            m_irq <= n_irq; m_pend <= n_pend;
            if (wb_valid) wb_seen++;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) chk("R9 irq", 32'(irq), 32'(m_irq));
    end

    task automatic offer(logic [31:0] w, bit is_in);
        @(negedge clk);
        sched_valid = 1; sched_word = w; sched_is_in = is_in;
        @(negedge clk);
        sched_valid = 0;
    endtask

    task automatic run_idle(logic [31:0] w);
        offer(w, 1);
        for (int k = 0; k < 3; k++) begin
            chk("R1 no req", 32'(req_valid), 0);
            chk("R1 no wb", 32'(wb_valid), 0);
            chk("R1 no err", 32'(prog_err), 0);
            chk("R1 ready", 32'(sched_ready), 1);
            @(negedge clk);
        end
    endtask

    task automatic run_bad(logic [31:0] w);
        logic [31:0] e;
        e = w; e[31] = 0;
        offer(w, 1);
        wb_exp++;
        chk("R3 no req", 32'(req_valid), 0);
        chk("R3 wb", 32'(wb_valid), 1);
        chk("R3 err", 32'(prog_err), 1);
        chk("R3 word", wb_word, e);
        @(negedge clk);
        chk("R3 err once", 32'(prog_err), 0);
        chk("R3 no req after", 32'(req_valid), 0);
    endtask

    task automatic run_good(logic [31:0] w, bit is_in, int bytes, bit be, bit bb,
                            bit nr, int req_dly, int rsp_dly, bit intrude);
        logic [31:0] e, ea, pp;
        pp = page_list[int'(w[14:12])*32 +: 32];
        ea = {pp[31:12], w[11:0]};
        e = w; e[31] = 0; e[30] |= be; e[29] |= bb; e[28] |= (nr & is_in);
        if (is_in) e[27:16] = 12'(bytes);
        offer(w, is_in);
        wb_exp++;
        for (int k = 0; k <= req_dly; k++) begin
            chk("R2 addr", req_addr, ea);
            chk("R2 len", 32'(req_len), 32'(w[27:16]));
            chk("R2 dir", 32'(req_is_in), 32'(is_in));
            chk("R4 valid held", 32'(req_valid), 1);
            chk("R10 busy", 32'(sched_ready), 0);
            if (k == req_dly) req_ready = 1;
            else if (intrude) begin
                sched_valid = 1; sched_word = mk(1, 0, 0, 0, 8, 1, 1, 0);
            end
            @(negedge clk);
            sched_valid = 0;
        end
        req_ready = 0;
        chk("R4 req taken", 32'(req_valid), 0);
        for (int k = 0; k <= rsp_dly; k++) begin
            chk("R5 wait", 32'(rsp_ready), 1);
            chk("R5 no early wb", 32'(wb_valid), 0);
            if (k == rsp_dly) begin
                rsp_valid = 1; rsp_bytes = 12'(bytes);
                rsp_buf_err = be; rsp_babble = bb; rsp_noresp = nr;
            end else if (intrude) begin
                sched_valid = 1; sched_word = mk(1, 0, 0, 0, 8, 0, 2, 0);
            end
            @(negedge clk);
            sched_valid = 0;
        end
        rsp_valid = 0; rsp_buf_err = 0; rsp_babble = 0; rsp_noresp = 0;
        chk("R5 wb", 32'(wb_valid), 1);
        chk("R6 R7 R8 word", wb_word, e);
        chk("R3 no err", 32'(prog_err), 0);
        @(negedge clk);
        chk("R5 wb single", 32'(wb_valid), 0);
        chk("R10 ready again", 32'(sched_ready), 1);
        chk("R10 intruder ignored", 32'(req_valid), 0);
    endtask

    task automatic tick();
        @(negedge clk); thresh_tick = 1;
        @(negedge clk); thresh_tick = 0;
    endtask

    initial begin
        for (int i = 0; i < NP; i++)
            page_list[i*32 +: 32] = 32'h1000_0000 + 32'(i) * 32'h0001_3000 + 32'h0000_0ABC;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R10 reset ready", 32'(sched_ready), 1);
        chk("R1 reset req", 32'(req_valid), 0);
        chk("R5 reset wb", 32'(wb_valid), 0);
        chk("R9 reset irq", 32'(irq), 0);
        chk("R3 reset err", 32'(prog_err), 0);

        run_idle(mk(0, 0, 0, 0, 100, 1, 2, 16));
        run_good(mk(1, 0, 0, 0, 100, 0, 0, 12'h123), 0, 5, 0, 0, 0, 0, 0, 0);
        run_good(mk(1, 0, 0, 0, 3072, 0, 6, 12'hFFF), 1, 1000, 0, 1, 0, 3, 2, 1);
        run_good(mk(1, 0, 1, 0, 512, 0, 3, 0), 1, 0, 1, 0, 1, 1, 0, 0);
        run_good(mk(1, 0, 0, 0, 40, 0, 4, 7), 0, 40, 0, 0, 1, 0, 1, 0);
        run_good(mk(1, 1, 0, 1, 64, 0, 5, 9), 0, 3, 0, 0, 0, 0, 0, 0);
        run_bad(mk(1, 0, 0, 0, 10, 0, 7, 4));
        run_bad(mk(1, 0, 0, 0, 3073, 0, 0, 4));

        // R9: two completions merge, held until ack
        run_good(mk(1, 0, 0, 0, 16, 1, 1, 0), 1, 16, 0, 0, 0, 0, 0, 0);
        repeat (2) @(negedge clk);
        run_good(mk(1, 0, 0, 0, 16, 1, 2, 0), 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R9 no irq before tick", 32'(irq), 0);
        tick();
        chk("R9 irq after tick", 32'(irq), 1);
        tick();
        repeat (3) @(negedge clk);
        chk("R9 irq held", 32'(irq), 1);
        irq_ack = 1; @(negedge clk); irq_ack = 0;
        chk("R9 ack clears", 32'(irq), 0);
        tick();
        chk("R9 merged single", 32'(irq), 0);
        run_good(mk(1, 0, 0, 0, 16, 0, 0, 0), 1, 4, 0, 0, 0, 0, 0, 0);
        tick();
        chk("R9 no ioc no irq", 32'(irq), 0);
        run_bad(mk(1, 0, 0, 0, 4000, 1, 0, 0));
        @(negedge clk); thresh_tick = 1; irq_ack = 1;
        @(negedge clk); thresh_tick = 0; irq_ack = 0;
        chk("R9 set beats ack", 32'(irq), 1);

        repeat (2) @(negedge clk);
        chk("R5 write-back count", 32'(wb_seen), 32'(wb_exp));
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule